// File: doc/BRIEF.md
# Legacy Serial Port Register Front End

This block presents the register set of a classic FIFO-less serial port to a host over a small register bus. It has no divisor latch, no bit shifting and no baud timing. Received bytes come in on a valid/ready byte stream. Bytes the host writes leave at once on a one-cycle valid output. A level interrupt output follows the interrupt-identification register.

The host bus uses a 3-bit address, a read strobe and a write strobe, and the bench never raises both strobes in the same cycle. Read data is combinational during the read strobe and shows the state from before that access. Any side effect of the access takes effect at the clock edge that ends the strobe cycle.

Back-pressure on the receive stream works as follows. `rx_ready` is low while a byte is held, because line-status RX-ready is set. It is also low during any cycle in which the host reads offset 0. A byte transfers on a clock edge where `rx_valid` and `rx_ready` are both high, and the sender must hold its byte until then. The transmit output has no back-pressure. Register offsets are: 0 data, 1 interrupt enable, 2 interrupt identification (read) / FIFO control (write), 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch.

Top module: `serial_port_front`

## Requirements
- R1: After reset, the registers read as follows: interrupt identification 0x01, line status 0x60, scratch 0xFF, interrupt enable 0x00, line control 0x00 and modem control 0x00. `irq` is low and `rx_ready` is high.
- R2: A stream transfer latches the byte and sets line-status bit 0 (RX-ready). While that bit is set, `rx_ready` stays low. A byte offered during that time is taken only after the host reads offset 0.
- R3: If interrupt-enable bit 0 is set when a byte is taken, identification bit 2 (value 0x04) is set and identification bit 0 is cleared.
- R4: A write to offset 0 raises `tx_valid` for exactly the next cycle, with `tx_data` equal to the written byte. If interrupt-enable bit 1 is set, identification bit 1 (value 0x02) is set and bit 0 is cleared.
- R5: A read of offset 0 while RX-ready is set returns the held byte, then clears RX-ready and zeroes the held byte. A read while RX-ready is clear returns the held value, which is 0x00. Every read of offset 0 clears identification bit 2.
- R6: A read of offset 2 returns the identification value, then clears identification bit 1.
- R7: If a clear leaves the identification value at 0x00, the value becomes 0x01.
- R8: `irq` is high exactly when identification bit 0 is 0.
- R9: A read of offset 5 returns 0x60 OR'd with RX-ready in bit 0. Writes to offsets 5 and 6 change nothing that can be read.
- R10: A read of offset 6 always returns 0xB0: bit 7 carrier detect, bit 5 data set ready, bit 4 clear to send.
- R11: A read of offset 7 returns the bitwise complement of the last byte written there.
- R12: Offsets 1, 3 and 4 read back as written. Line-control bit 7 does not remap offsets 0 and 1. A write to offset 2 changes nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during bus_rd |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Front end can take a byte |
| tx_data | output | 8 | Transmitted byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The main path runs under all four combinations of the two interrupt-enable bits. This shows that each source is set only when its own enable bit is set, and that each read clears only its own identification bit. A separate sequence lets both sources fire and then clears them one at a time, which shows the idle-restore rule apart from a plain bit clear. A byte is offered while another is held, which shows that back-pressure holds the second byte until the data read and not merely until the next cycle. A full sweep of all 256 scratch values separates inversion from plain storage for every bit.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_IEN  = 3'd1;
  localparam logic [AW-1:0] OFS_IID  = 3'd2;
  localparam logic [AW-1:0] OFS_LCTL = 3'd3;
  localparam logic [AW-1:0] OFS_MCTL = 3'd4;
  localparam logic [AW-1:0] OFS_LSTS = 3'd5;
  localparam logic [AW-1:0] OFS_MSTS = 3'd6;
  localparam logic [AW-1:0] OFS_SCR  = 3'd7;

  // plain storage registers, index order used by the top
  localparam int PLAIN_N = 4;
  localparam logic [AW-1:0] PLAIN_OFS [PLAIN_N] = '{OFS_IEN, OFS_LCTL, OFS_MCTL, OFS_SCR};

  localparam int IID_PEND_N = 0;
  localparam int IID_TX     = 1;
  localparam int IID_RX     = 2;
  localparam logic [DW-1:0] IID_IDLE = 8'h01;

  localparam logic [DW-1:0] LSTS_FIXED = 8'h60;
  localparam logic [DW-1:0] MSTS_FIXED = 8'hB0;
endpackage

// File: rtl/spf_plain_reg.sv
module spf_plain_reg #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [AW-1:0] OFS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr && addr == OFS) q <= wdata;
  end

  p_hold_unless_written_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS) |=> $stable(q));
endmodule

// File: rtl/spf_rx_hold.sv
module spf_rx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          host_take,
  output logic          accept,
  output logic [DW-1:0] held,
  output logic          full
);
  assign in_ready = !full && !host_take;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      full <= 1'b0;
    end else if (accept) begin
      held <= in_data;
      full <= 1'b1;
    end else if (host_take && full) begin
      held <= '0;
      full <= 1'b0;
    end
  end

  p_latch_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> full && held == $past(in_data));
  p_take_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_take && full |=> !full && held == '0);
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full && !host_take |=> full && $stable(held));
endmodule

// File: rtl/spf_int_id.sv
module spf_int_id
  import serial_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_rx,
  input  logic          ev_tx,
  input  logic          clr_rx,
  input  logic          clr_tx,
  output logic [DW-1:0] iid
);
  logic [DW-1:0] clr_mask, set_mask, cleared, nxt;

  always_comb begin
    clr_mask = '0;
    clr_mask[IID_RX] = clr_rx;
    clr_mask[IID_TX] = clr_tx;
    set_mask = '0;
    set_mask[IID_RX] = ev_rx;
    set_mask[IID_TX] = ev_tx;
    cleared = iid & ~clr_mask;
    if ((clr_rx || clr_tx) && cleared == '0) cleared = IID_IDLE;
    nxt = cleared;
    if (set_mask != '0) begin
      nxt = cleared | set_mask;
      nxt[IID_PEND_N] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iid <= IID_IDLE;
    else iid <= nxt;
  end

  p_never_zero_r7: assert property (@(posedge clk) disable iff (!rst_n) iid != '0);
  p_tx_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx |=> iid[IID_TX] && !iid[IID_PEND_N]);
  p_rx_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |=> iid[IID_RX] && !iid[IID_PEND_N]);
  p_tx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tx && !ev_tx |=> !iid[IID_TX]);
  p_rx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rx && !ev_rx |=> !iid[IID_RX]);
endmodule

// File: rtl/serial_port_front.sv
module serial_port_front
  import serial_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic          irq
);
  logic [DW-1:0] plain_q [PLAIN_N];
  logic [DW-1:0] ien, lctl, mctl, scr, held, iid;
  logic          wr_data, rd_data, rd_iid, accept, full;

  assign wr_data = bus_wr && bus_addr == OFS_DATA;
  assign rd_data = bus_rd && bus_addr == OFS_DATA;
  assign rd_iid  = bus_rd && bus_addr == OFS_IID;

  for (genvar g = 0; g < PLAIN_N; g++) begin : g_plain
    spf_plain_reg #(.DW(DW), .AW(AW), .OFS(PLAIN_OFS[g])) u_reg (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .q(plain_q[g]));
  end

  assign ien  = plain_q[0];
  assign lctl = plain_q[1];
  assign mctl = plain_q[2];
  assign scr  = plain_q[3];

  spf_rx_hold #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_data(rx_data), .in_valid(rx_valid),
    .in_ready(rx_ready), .host_take(rd_data), .accept(accept),
    .held(held), .full(full));

  spf_int_id u_iid (
    .clk(clk), .rst_n(rst_n),
    .ev_rx(accept && ien[0]), .ev_tx(wr_data && ien[1]),
    .clr_rx(rd_data), .clr_tx(rd_iid), .iid(iid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr_data;
      if (wr_data) tx_data <= bus_wdata;
    end
  end

  assign irq = !iid[IID_PEND_N];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_DATA: bus_rdata = held;
        OFS_IEN:  bus_rdata = ien;
        OFS_IID:  bus_rdata = iid;
        OFS_LCTL: bus_rdata = lctl;
        OFS_MCTL: bus_rdata = mctl;
        OFS_LSTS: bus_rdata = LSTS_FIXED | {{(DW-1){1'b0}}, full};
        OFS_MSTS: bus_rdata = MSTS_FIXED;
        OFS_SCR:  bus_rdata = ~scr;
        default:  bus_rdata = '0;
      endcase
    end
  end

  p_tx_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> tx_valid && tx_data == $past(bus_wdata));
  p_tx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> !tx_valid);
  p_ready_low_when_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !rx_ready);
endmodule

// File: tb/tb_serial_port_front.sv
module tb_serial_port_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       irq;

  int checks = 0, errors = 0;
  logic [7:0] m_iid;
  logic [7:0] rd;
  logic       seen_txv;
  logic [7:0] seen_txd;

  always #4 clk = ~clk;

  serial_port_front dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
    seen_txv = tx_valid; seen_txd = tx_data;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    rx_data = d; rx_valid = 1'b1;
    #1 while (!rx_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  // model of the identification rules
  function automatic logic [7:0] iid_apply(input logic [7:0] v, input logic [7:0] clr, input logic [7:0] set);
    logic [7:0] r;
    r = v & ~clr;
    if (clr != 0 && r == 0) r = 8'h01;
    if (set != 0) r = (r | set) & 8'hFE;
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 rx_ready", {7'b0, rx_ready}, 8'h01);
    bus_read(3'd2, rd); check("R1 iid", rd, 8'h01);
    bus_read(3'd5, rd); check("R1 lsts", rd, 8'h60);
    bus_read(3'd7, rd); check("R1 scr", rd, 8'hFF);
    bus_read(3'd1, rd); check("R1 ien", rd, 8'h00);
    bus_read(3'd3, rd); check("R1 lctl", rd, 8'h00);
    bus_read(3'd4, rd); check("R1 mctl", rd, 8'h00);
    bus_read(3'd6, rd); check("R10 msts", rd, 8'hB0);

    m_iid = 8'h01;
    for (int e = 0; e < 4; e++) begin
      logic [7:0] b;
      b = 8'h5A + 8'(e);
      bus_write(3'd1, 8'(e));
      push(b);
      if (e[0]) m_iid = iid_apply(m_iid, 8'h00, 8'h04);
      check("R3 irq after rx", {7'b0, irq}, {7'b0, ~m_iid[0]});
      bus_read(3'd5, rd); check("R2 lsts held", rd, 8'h61);
      // a second byte offered while one is held is not taken
      @(negedge clk); rx_data = 8'hEE; rx_valid = 1'b1;
      repeat (3) begin #1 check("R2 ready low while held", {7'b0, rx_ready}, 8'h00); @(negedge clk); end
      rx_valid = 1'b0;
      bus_write(3'd0, 8'h30 + 8'(e));
      check("R4 tx_valid", {7'b0, seen_txv}, 8'h01);
      check("R4 tx_data", seen_txd, 8'h30 + 8'(e));
      #8 check("R4 tx single", {7'b0, tx_valid}, 8'h00);
      if (e[1]) m_iid = iid_apply(m_iid, 8'h00, 8'h02);
      check("R8 irq", {7'b0, irq}, {7'b0, ~m_iid[0]});
      bus_read(3'd2, rd); check("R6 iid read", rd, m_iid);
      m_iid = iid_apply(m_iid, 8'h02, 8'h00);
      check("R8 irq after iid read", {7'b0, irq}, {7'b0, ~m_iid[0]});
      bus_read(3'd0, rd); check("R5 data read", rd, b);
      m_iid = iid_apply(m_iid, 8'h04, 8'h00);
      bus_read(3'd5, rd); check("R5 lsts cleared", rd, 8'h60);
      bus_read(3'd0, rd); check("R5 empty read", rd, 8'h00);
      m_iid = iid_apply(m_iid, 8'h04, 8'h00);
      bus_read(3'd2, rd); check("R7 iid idle", rd, m_iid);
      check("R8 irq idle", {7'b0, irq}, 8'h00);
    end

    // R7 both sources, cleared one at a time
    bus_write(3'd1, 8'h03);
    push(8'hA1);
    bus_write(3'd0, 8'h77);
    bus_read(3'd2, rd); check("R7 both set", rd, 8'h06);
    bus_read(3'd2, rd); check("R7 tx cleared rx stays", rd, 8'h04);
    check("R8 irq rx pending", {7'b0, irq}, 8'h01);
    // R2 pending byte taken only after data read
    @(negedge clk); rx_data = 8'hC3; rx_valid = 1'b1;
    bus_read(3'd0, rd); check("R5 held byte", rd, 8'hA1);
    #1 check("R2 ready after read", {7'b0, rx_ready}, 8'h01);
    @(posedge clk); #1 rx_valid = 1'b0;
    bus_read(3'd2, rd); check("R3 rx set again", rd, 8'h04);
    bus_read(3'd0, rd); check("R2 second byte", rd, 8'hC3);
    bus_read(3'd2, rd); check("R7 restore to idle", rd, 8'h01);
    check("R8 irq low", {7'b0, irq}, 8'h00);

    // R9 ignored writes to status offsets
    bus_write(3'd5, 8'hFF);
    bus_write(3'd6, 8'h00);
    bus_read(3'd5, rd); check("R9 lsts after write", rd, 8'h60);
    bus_read(3'd6, rd); check("R10 msts after write", rd, 8'hB0);
    bus_read(3'd2, rd); check("R9 iid unchanged", rd, 8'h01);

    // R12 plain regs, line-control bit 7, offset 2 write
    bus_write(3'd1, 8'h00);
    bus_write(3'd4, 8'h1B); bus_read(3'd4, rd); check("R12 mctl", rd, 8'h1B);
    bus_write(3'd3, 8'h83); bus_read(3'd3, rd); check("R12 lctl", rd, 8'h83);
    bus_write(3'd0, 8'h11);
    check("R12 data not remapped", seen_txd, 8'h11);
    check("R12 tx strobe with lctl7", {7'b0, seen_txv}, 8'h01);
    bus_write(3'd1, 8'hF0); bus_read(3'd1, rd); check("R12 ien not remapped", rd, 8'hF0);
    bus_write(3'd2, 8'hFF);
    bus_read(3'd2, rd); check("R12 offset2 write no effect", rd, 8'h01);
    check("R12 irq after offset2 write", {7'b0, irq}, 8'h00);
    bus_read(3'd1, rd); check("R12 ien intact", rd, 8'hF0);

    // R11 scratch sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(3'd7, 8'(v));
      bus_read(3'd7, rd); check("R11 scr", rd, ~8'(v));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule